// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the controller of a multicycle processor datapath for a small load/store instruction set. It walks each instruction through up to five steps: fetch, decode, execute or address generation, memory access and write-back. In each state it drives one complete set of datapath controls. The datapath reads these controls as stable Moore outputs of the state register. Supported instructions are register-to-register (R-type), load word, store word, branch-if-equal and jump.

There are ten states. `FETCH` (0) reads the instruction and advances the PC. `DECODE` (1) adds the shifted offset to the PC ahead of time as a possible branch target, then dispatches on the opcode. The remaining states are:

- `MEMADR` (2) computes the effective address for loads and stores.
- `LDRD` (3) reads data memory and `LDWB` (4) writes the loaded word to the register file.
- `STWR` (5) writes data memory.
- `ALUEX` (6) runs the register-to-register operation and `ALUWB` (7) writes its result.
- `BRCMP` (8) compares the operands and may redirect the PC.
- `JMP` (9) loads the jump target.

The transitions are:

- `FETCH`→`DECODE`.
- `DECODE`→`MEMADR` / `ALUEX` / `BRCMP` / `JMP` / `FETCH`, according to the opcode class.
- `MEMADR`→`LDRD` for a load and `MEMADR`→`STWR` for a store.
- `LDRD`→`LDWB`.
- `ALUEX`→`ALUWB`.
- `LDWB`, `STWR`, `ALUWB`, `BRCMP` and `JMP` each go back to `FETCH`.

The opcode is sampled only in `DECODE`. Whether a memory instruction is a load or a store is remembered from that cycle, so the opcode input is free to change in every other state.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the machine in `FETCH` from any state. `FETCH` outputs are visible in the cycle after that edge.
- R2: In `FETCH`, `pc_we`, `mem_rd` and `ir_we` are 1. `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=2'b01, `alu_op`=2'b00 and `pc_src`=2'b00. The next state is always `DECODE`.
- R3: In `DECODE`, `alu_a_sel`=0, `alu_b_sel`=2'b11 and `alu_op`=2'b00. The opcode selects the next state:
  - 6'b100011 (load) or 6'b101011 (store) → `MEMADR`
  - 6'b000000 (R-type) → `ALUEX`
  - 6'b000100 (branch) → `BRCMP`
  - 6'b000010 (jump) → `JMP`
- R4: In `MEMADR`, `alu_a_sel`=1, `alu_b_sel`=2'b10 and `alu_op`=2'b00. The next state is `LDRD` for a load and `STWR` for a store.
- R5: `LDRD` drives `mem_rd`=1 and `addr_sel`=1, then goes to `LDWB`. `LDWB` drives `reg_we`=1, `reg_dst`=0 and `mem_to_reg`=1, then goes to `FETCH`.
- R6: `STWR` drives `mem_wr`=1 and `addr_sel`=1, then goes to `FETCH`.
- R7: `ALUEX` drives `alu_a_sel`=1, `alu_b_sel`=2'b00 and `alu_op`=2'b10, then goes to `ALUWB`. `ALUWB` drives `reg_we`=1, `reg_dst`=1 and `mem_to_reg`=0, then goes to `FETCH`.
- R8: `BRCMP` drives `alu_a_sel`=1, `alu_b_sel`=2'b00, `alu_op`=2'b01, `pc_we_cond`=1 and `pc_src`=2'b01, then goes to `FETCH`.
- R9: `JMP` drives `pc_we`=1 and `pc_src`=2'b10, then goes to `FETCH`.
- R10: An opcode outside the five listed encodings in `DECODE` sends the machine straight back to `FETCH`.
- R11: The opcode input has no effect in any state other than `DECODE`. In particular, the load/store choice made at `MEMADR` is the one decoded in `DECODE`.
- R12: Each instruction spans a fixed number of cycles from `FETCH` until the next `FETCH`:
  - load: 5
  - store: 4
  - R-type: 4
  - branch: 3
  - jump: 3
  - unrecognized: 2
- R13: Every control not named for a state is 0 in that state, so `reg_we`, `mem_wr` and `pc_we_cond` are inactive outside their own states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write gated by the ALU zero flag |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_we | output | 1 | Instruction register write |
| mem_to_reg | output | 1 | Register write data source: 0 ALU result, 1 memory data |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 from function field |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| reg_we | output | 1 | Register file write |
| reg_dst | output | 1 | Destination register field: 0 rt, 1 rd |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode and the five encodings listed in R3. With these defaults, all ten states and every dispatch edge out of `DECODE` and `MEMADR` can be reached. The bench compares the full 16-bit control word in every cycle of every instruction class, including back-to-back instructions and several unrecognized opcodes. Directed cases then check reset in the middle of an instruction, and an opcode that changes after `DECODE` and would otherwise turn a load into a store or a jump.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int STATE_W = 4;
    localparam int SEL_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_MEMADR = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_ALUEX  = 4'd6,
        ST_ALUWB  = 4'd7,
        ST_BRCMP  = 4'd8,
        ST_JMP    = 4'd9
    } state_t;

    typedef enum logic [2:0] {
        OC_RTYPE,
        OC_LOAD,
        OC_STORE,
        OC_BRANCH,
        OC_JUMP,
        OC_OTHER
    } opclass_t;

    typedef struct packed {
        logic             pc_we;
        logic             pc_we_cond;
        logic             addr_sel;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_we;
        logic             mem_to_reg;
        logic [SEL_W-1:0] pc_src;
        logic [SEL_W-1:0] alu_op;
        logic             alu_a_sel;
        logic [SEL_W-1:0] alu_b_sel;
        logic             reg_we;
        logic             reg_dst;
    } ctrl_t;

endpackage

// File: rtl/mcc_opclass.sv
module mcc_opclass
    import mcc_pkg::*;
#(
    parameter int            OP_W      = 6,
    parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
    parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
    input  logic [OP_W-1:0] opcode,
    output opclass_t        op_class
);

    always_comb begin
        if (opcode == OP_RTYPE)       op_class = OC_RTYPE;
        else if (opcode == OP_LOAD)   op_class = OC_LOAD;
        else if (opcode == OP_STORE)  op_class = OC_STORE;
        else if (opcode == OP_BRANCH) op_class = OC_BRANCH;
        else if (opcode == OP_JUMP)   op_class = OC_JUMP;
        else                          op_class = OC_OTHER;
    end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_t   state,
    input  opclass_t op_class,
    input  logic     store_q,
    output state_t   state_nxt,
    output logic     store_nxt
);

    always_comb begin
        store_nxt = store_q;
        unique case (state)
            ST_FETCH:  state_nxt = ST_DECODE;
            ST_DECODE: begin
                store_nxt = (op_class == OC_STORE);
                unique case (op_class)
                    OC_LOAD,
                    OC_STORE:  state_nxt = ST_MEMADR;
                    OC_RTYPE:  state_nxt = ST_ALUEX;
                    OC_BRANCH: state_nxt = ST_BRCMP;
                    OC_JUMP:   state_nxt = ST_JMP;
                    default:   state_nxt = ST_FETCH;
                endcase
            end
            ST_MEMADR: state_nxt = store_q ? ST_STWR : ST_LDRD;
            ST_LDRD:   state_nxt = ST_LDWB;
            ST_ALUEX:  state_nxt = ST_ALUWB;
            ST_LDWB,
            ST_STWR,
            ST_ALUWB,
            ST_BRCMP,
            ST_JMP:    state_nxt = ST_FETCH;
            default:   state_nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  state_t state,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_FETCH: begin
                ctrl.pc_we     = 1'b1;
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_we     = 1'b1;
                ctrl.alu_b_sel = 2'b01;
            end
            ST_DECODE: begin
                ctrl.alu_b_sel = 2'b11;
            end
            ST_MEMADR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = 2'b10;
            end
            ST_LDRD: begin
                ctrl.mem_rd   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctrl.reg_we     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            ST_STWR: begin
                ctrl.mem_wr   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_ALUEX: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_op    = 2'b10;
            end
            ST_ALUWB: begin
                ctrl.reg_we  = 1'b1;
                ctrl.reg_dst = 1'b1;
            end
            ST_BRCMP: begin
                ctrl.alu_a_sel  = 1'b1;
                ctrl.alu_op     = 2'b01;
                ctrl.pc_we_cond = 1'b1;
                ctrl.pc_src     = 2'b01;
            end
            ST_JMP: begin
                ctrl.pc_we  = 1'b1;
                ctrl.pc_src = 2'b10;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
    import mcc_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
    parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  opcode,
    output logic             pc_we,
    output logic             pc_we_cond,
    output logic             addr_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_we,
    output logic             mem_to_reg,
    output logic [1:0]       pc_src,
    output logic [1:0]       alu_op,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic             reg_we,
    output logic             reg_dst
);

    state_t   state_q;
    state_t   state_nxt;
    logic     store_q;
    logic     store_nxt;
    opclass_t op_class;
    ctrl_t    ctrl;

    mcc_opclass #(
        .OP_W      (OP_W),
        .OP_RTYPE  (OP_RTYPE),
        .OP_LOAD   (OP_LOAD),
        .OP_STORE  (OP_STORE),
        .OP_BRANCH (OP_BRANCH),
        .OP_JUMP   (OP_JUMP)
    ) u_opclass (
        .opcode   (opcode),
        .op_class (op_class)
    );

    mcc_next_state u_next (
        .state     (state_q),
        .op_class  (op_class),
        .store_q   (store_q),
        .state_nxt (state_nxt),
        .store_nxt (store_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            store_q <= 1'b0;
        end else begin
            state_q <= state_nxt;
            store_q <= store_nxt;
        end
    end

    mcc_out_decode u_out (
        .state (state_q),
        .ctrl  (ctrl)
    );

    assign pc_we      = ctrl.pc_we;
    assign pc_we_cond = ctrl.pc_we_cond;
    assign addr_sel   = ctrl.addr_sel;
    assign mem_rd     = ctrl.mem_rd;
    assign mem_wr     = ctrl.mem_wr;
    assign ir_we      = ctrl.ir_we;
    assign mem_to_reg = ctrl.mem_to_reg;
    assign pc_src     = ctrl.pc_src;
    assign alu_op     = ctrl.alu_op;
    assign alu_a_sel  = ctrl.alu_a_sel;
    assign alu_b_sel  = ctrl.alu_b_sel;
    assign reg_we     = ctrl.reg_we;
    assign reg_dst    = ctrl.reg_dst;

endmodule

// File: rtl/mcc_ctrl_fsm_chk.sv
module mcc_ctrl_fsm_chk (
    input logic       clk,
    input logic       rst,
    input logic       pc_we,
    input logic       pc_we_cond,
    input logic       addr_sel,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_we,
    input logic       mem_to_reg,
    input logic [1:0] pc_src,
    input logic [1:0] alu_op,
    input logic       alu_a_sel,
    input logic [1:0] alu_b_sel,
    input logic       reg_we,
    input logic       reg_dst
);

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk) rst |=> (ir_we && pc_we && mem_rd));

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> (alu_b_sel == 2'b11 && !ir_we));

    // R5
    load_rd_to_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_sel) |=> (reg_we && mem_to_reg && !reg_dst));

    // R6
    store_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_we);

    // R7
    alu_ex_to_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b10) |=> (reg_we && reg_dst && !mem_to_reg));

    // R8
    branch_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        pc_we_cond |=> ir_we);

    // R9
    jump_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_src == 2'b10) |=> ir_we);

    // R13
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr) && !(reg_we && (mem_wr || pc_we_cond || alu_a_sel)));

endmodule

bind mcc_ctrl_fsm mcc_ctrl_fsm_chk u_chk (.*);

// File: tb/mcc_ctrl_fsm_tb.sv
module mcc_ctrl_fsm_tb;

    localparam int TCLK = 10;
    localparam int NPROG = 10;

    // entry: {2'b0, opcode[5:0], length[3:0], five 4-bit state ids}
    localparam logic [31:0] PROG [0:NPROG-1] = '{
        {2'b00, 6'b100011, 4'd5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4},
        {2'b00, 6'b101011, 4'd4, 4'd0, 4'd1, 4'd2, 4'd5, 4'd0},
        {2'b00, 6'b000000, 4'd4, 4'd0, 4'd1, 4'd6, 4'd7, 4'd0},
        {2'b00, 6'b000100, 4'd3, 4'd0, 4'd1, 4'd8, 4'd0, 4'd0},
        {2'b00, 6'b000010, 4'd3, 4'd0, 4'd1, 4'd9, 4'd0, 4'd0},
        {2'b00, 6'b111111, 4'd2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0},
        {2'b00, 6'b101011, 4'd4, 4'd0, 4'd1, 4'd2, 4'd5, 4'd0},
        {2'b00, 6'b100011, 4'd5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4},
        {2'b00, 6'b000001, 4'd2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0},
        {2'b00, 6'b000000, 4'd4, 4'd0, 4'd1, 4'd6, 4'd7, 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic       pc_we, pc_we_cond, addr_sel, mem_rd, mem_wr, ir_we, mem_to_reg;
    logic [1:0] pc_src, alu_op, alu_b_sel;
    logic       alu_a_sel, reg_we, reg_dst;

    int n_checks = 0;
    int n_errors = 0;

    always #(TCLK/2) clk = ~clk;

    mcc_ctrl_fsm u_dut (
        .clk        (clk),
        .rst        (rst),
        .opcode     (opcode),
        .pc_we      (pc_we),
        .pc_we_cond (pc_we_cond),
        .addr_sel   (addr_sel),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .ir_we      (ir_we),
        .mem_to_reg (mem_to_reg),
        .pc_src     (pc_src),
        .alu_op     (alu_op),
        .alu_a_sel  (alu_a_sel),
        .alu_b_sel  (alu_b_sel),
        .reg_we     (reg_we),
        .reg_dst    (reg_dst)
    );

    // packing: pc_we,pc_we_cond,addr_sel,mem_rd,mem_wr,ir_we,mem_to_reg,
    //          pc_src[2],alu_op[2],alu_a_sel,alu_b_sel[2],reg_we,reg_dst
    function automatic logic [15:0] exp_vec(input int st);
        case (st)
            0: return {7'b1001010, 2'b00, 2'b00, 1'b0, 2'b01, 2'b00};
            1: return {7'b0000000, 2'b00, 2'b00, 1'b0, 2'b11, 2'b00};
            2: return {7'b0000000, 2'b00, 2'b00, 1'b1, 2'b10, 2'b00};
            3: return {7'b0011000, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00};
            4: return {7'b0000001, 2'b00, 2'b00, 1'b0, 2'b00, 2'b10};
            5: return {7'b0010100, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00};
            6: return {7'b0000000, 2'b00, 2'b10, 1'b1, 2'b00, 2'b00};
            7: return {7'b0000000, 2'b00, 2'b00, 1'b0, 2'b00, 2'b11};
            8: return {7'b0100000, 2'b01, 2'b01, 1'b1, 2'b00, 2'b00};
            9: return {7'b1000000, 2'b10, 2'b00, 1'b0, 2'b00, 2'b00};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string req_of(input int st);
        case (st)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return "R5";
            5: return "R6";
            6, 7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R13";
        endcase
    endfunction

    // full control word compared, so R13 zero fields are checked every time
    task automatic chk_state(input int st, input string tag);
        logic [15:0] got;
        got = {pc_we, pc_we_cond, addr_sel, mem_rd, mem_wr, ir_we, mem_to_reg,
               pc_src, alu_op, alu_a_sel, alu_b_sel, reg_we, reg_dst};
        n_checks++;
        if (got !== exp_vec(st)) begin
            n_errors++;
            $display("FAIL %s state %0d: got %h expected %h", tag, st, got, exp_vec(st));
        end
    endtask

    initial begin
        #(TCLK * 200000);
        n_errors++;
        $display("FAIL R12 watchdog: got no end expected end");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_state(0, "R1 reset");
        rst = 1'b0;

        // table walk: every class, back to back
        for (int i = 0; i < NPROG; i++) begin
            logic [31:0] e;
            int len;
            e = PROG[i];
            opcode = e[29:24];
            len = int'(e[23:20]);
            for (int k = 0; k < len; k++) begin
                int st;
                st = int'(e[19-4*k -: 4]);
                chk_state(st, (len == 2 && k == 1) ? "R10" : req_of(st));
                @(negedge clk);
            end
            // R12: back in fetch exactly len cycles after this instruction started
            chk_state(0, "R12");
        end

        // R10: unrecognized opcode returns to fetch after decode
        opcode = 6'b100000;
        @(negedge clk);
        chk_state(1, "R10");
        @(negedge clk);
        chk_state(0, "R10");

        // R11: opcode changes after decode must not alter a load
        opcode = 6'b100011;
        @(negedge clk);
        chk_state(1, "R11");
        @(negedge clk);
        opcode = 6'b101011;
        chk_state(2, "R11");
        @(negedge clk);
        opcode = 6'b000010;
        chk_state(3, "R11");
        @(negedge clk);
        opcode = 6'b000000;
        chk_state(4, "R11");
        @(negedge clk);
        chk_state(0, "R11");

        // R11: store stays a store when opcode flips to load during address step
        opcode = 6'b101011;
        @(negedge clk);
        @(negedge clk);
        opcode = 6'b100011;
        chk_state(2, "R11");
        @(negedge clk);
        chk_state(5, "R11");
        @(negedge clk);
        chk_state(0, "R11");

        // R1: reset in the middle of a load
        opcode = 6'b100011;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk_state(3, "R1 pre");
        rst = 1'b1;
        @(negedge clk);
        chk_state(0, "R1 mid");
        rst = 1'b0;
        opcode = 6'b000100;
        @(negedge clk);
        chk_state(1, "R1 resume");
        @(negedge clk);
        chk_state(8, "R1 resume");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule